// File: doc/BRIEF.md
# Cache Miss Status Handling Unit

This unit sits beside a cache's tag lookup and keeps track of misses that are still waiting on the next memory level. Each miss the lookup reports either joins an entry already pending for the same block or opens a new entry. Opening an entry sends exactly one command to memory. Joining an entry sends nothing and only adds the requester to that entry's target list. Write-only uncacheable traffic and dirty-block writebacks do not use an entry. They leave on a one-cycle write-buffer strobe.

Each entry carries one memory request. A small issue stage latches the lowest-index entry that has not yet sent its request and holds it on the request channel until the memory accepts it. When memory answers, the response-retire state machine takes over. It passes through **IDLE**, **INSTALL** and **DRAIN**:
- **IDLE → INSTALL** when an error-free response arrives for a fill entry.
- **IDLE → DRAIN** when the response carries an error, or belongs to an uncached entry.
- **INSTALL → DRAIN** after the single install-strobe cycle.
- **DRAIN → IDLE** once the last target has been handed back.

While in DRAIN, the queued targets are returned one per handshake, in the order they arrived.

Two stall outputs hold the requester off. One is raised when a single entry's target list becomes full. The other is raised when every entry is occupied.

Top module: `miss_track_unit`

## Requirements
- R1: After synchronous reset, no entry is valid. `lk_ready` and `mrsp_ready` are 1. `stall_tgt`, `stall_full`, `mreq_valid`, `tr_valid`, `wbuf_valid`, `blk_fill` and `blk_clr_rd` are 0.
- R2: A cacheable miss is compared with pending fill entries on its block address, which is the address with the low log2(BLK_BYTES) bits cleared. Addresses that differ only in those offset bits merge. Addresses in different blocks open separate entries.
- R3: A miss that merges adds a target to the existing entry and issues no memory request. Every target accepted into any entry, whether it opened the entry or merged into it, receives the next value of a shared order counter. The counter starts at 0 after reset.
- R4: A cacheable miss that opens an entry issues `mreq_cmd` according to the block state:
  - 2 (upgrade) when the block is resident (`lk_blk_valid`=1);
  - 1 (read-exclusive) when the block is absent and `lk_excl`=1;
  - 0 (read) otherwise.
  
  `mreq_addr` is the block address.
- R5: A cacheable write miss to a block that is resident but not writable pulses `blk_clr_rd` for one cycle, with `blk_clr_addr` set to the block address, in the cycle after the miss is accepted.
- R6: An uncacheable request that writes and does not read produces a `wbuf_valid` pulse carrying the full address and the ID in the cycle after acceptance, and opens no entry. Every other uncacheable request opens its own entry with command 3 and the full address, and is never merged.
- R7: A cacheable writeback (`lk_wb`=1) goes to the write-buffer strobe in the same way, and opens no entry.
- R8: When an entry's target count reaches NUM_TARGETS, `stall_tgt` rises and `lk_ready` falls. `stall_tgt` clears in the cycle after a memory response for that entry is accepted.
- R9: When all NUM_MSHR entries are valid, `stall_full`=1 and `lk_ready`=0.
- R10: When a fill entry receives an error-free response, `blk_fill` pulses for one cycle with the block address, in the cycle after the response is accepted. Its targets follow. A response carrying an error, or any response to an uncached entry, produces no `blk_fill`. Every target of an entry answered with an error is returned with `tr_err`=1.
- R11: The targets of a retiring entry appear on `tr_*` in allocation order, one per `tr_valid`&&`tr_ready` handshake, and are held stable while `tr_ready`=0. The entry is freed after its last target is taken.
- R12: A new entry takes the lowest free index. The request channel presents the lowest-index unsent entry with `mreq_tag` equal to that index, and holds `mreq_valid`, `mreq_tag` and `mreq_addr` stable until `mreq_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | A lookup miss is presented |
| lk_ready | output | 1 | The unit can take a miss |
| lk_addr | input | ADDR_W | Request byte address |
| lk_id | input | ID_W | Requester target ID |
| lk_uncache | input | 1 | Request is uncacheable |
| lk_read | input | 1 | Request reads |
| lk_write | input | 1 | Request writes |
| lk_wb | input | 1 | Request is a dirty-block writeback |
| lk_excl | input | 1 | Exclusive ownership is needed |
| lk_blk_valid | input | 1 | Tag lookup found the block resident |
| lk_blk_writable | input | 1 | The resident block is writable |
| stall_tgt | output | 1 | Stall: an entry's target list is full |
| stall_full | output | 1 | Stall: no free entry |
| wbuf_valid | output | 1 | Write-buffer strobe |
| wbuf_addr | output | ADDR_W | Write-buffer address |
| wbuf_id | output | ID_W | Write-buffer requester ID |
| blk_clr_rd | output | 1 | Clear the readable bit of a block |
| blk_clr_addr | output | ADDR_W | Block for the readable-bit clear |
| blk_fill | output | 1 | Install the returned block |
| blk_fill_addr | output | ADDR_W | Block being installed |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | ADDR_W | Memory request address |
| mreq_cmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 uncached read |
| mreq_tag | output | IDX_W | Entry index of the request |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_ready | output | 1 | Unit can take a response |
| mrsp_tag | input | IDX_W | Entry index being answered |
| mrsp_err | input | 1 | Response carries an error |
| tr_valid | output | 1 | Target return valid |
| tr_ready | input | 1 | Requester takes the target |
| tr_id | output | ID_W | Returned target ID |
| tr_order | output | ORD_W | Order tag of the returned target |
| tr_err | output | 1 | Returned target saw an error |

## Verification
The bench targets the following corner cases, and names the symptom each wrong design would show:
- **Address offset bits.** Two addresses inside one block must merge into a single request. A matcher that compares offset bits would issue a second request, and the request scoreboard would flag it.
- **Upgrade command and readable clear.** The bench checks the upgrade command and the readable-bit clear together. A design that picks read-exclusive for a resident read-only block, or that drops the clear, shows a wrong command or a missing strobe.
- **Target-stall release.** A fourth miss to one block must raise the target stall, and the stall must drop only after that entry's response. A design that clears it early or never is caught at the cycle after acceptance.
- **Error responses.** A fill answered with an error must not install the block. A design that still installs is caught by a `blk_fill` check.
- **Uncached reads.** Two uncached reads to the same address must open two entries. A design that merges them is caught.
- **Back-pressure on returns.** Targets must stay in order and held while `tr_ready` is low. A design that drops or reorders them under back-pressure fails the return scoreboard.

// File: rtl/mt_pkg.sv
package mt_pkg;

    typedef enum logic [1:0] {
        CMD_READ     = 2'd0,
        CMD_READ_EX  = 2'd1,
        CMD_UPGRADE  = 2'd2,
        CMD_UNC_READ = 2'd3
    } mem_cmd_e;

    typedef enum logic [1:0] {
        RT_CACHE    = 2'd0,
        RT_UNCACHED = 2'd1,
        RT_WBUF     = 2'd2
    } route_e;

    typedef enum logic [1:0] {
        RS_IDLE    = 2'd0,
        RS_INSTALL = 2'd1,
        RS_DRAIN   = 2'd2
    } ret_state_e;

endpackage

// File: rtl/mt_cmd_sel.sv
module mt_cmd_sel
    import mt_pkg::*;
(
    input  logic     uncache,
    input  logic     is_read,
    input  logic     is_write,
    input  logic     is_wb,
    input  logic     need_excl,
    input  logic     blk_valid,
    input  logic     blk_writable,
    output route_e   route,
    output mem_cmd_e cmd,
    output logic     clr_rd
);
    always_comb begin
        route  = RT_CACHE;
        cmd    = CMD_READ;
        clr_rd = 1'b0;
        if (uncache) begin
            if (is_write && !is_read) begin
                route = RT_WBUF;
            end else begin
                route = RT_UNCACHED;
                cmd   = CMD_UNC_READ;
            end
        end else if (is_wb) begin
            route = RT_WBUF;
        end else if (blk_valid) begin
            // resident but needing ownership: ask only for permission
            cmd    = CMD_UPGRADE;
            clr_rd = is_write && !blk_writable;
        end else begin
            cmd = need_excl ? CMD_READ_EX : CMD_READ;
        end
    end
endmodule

// File: rtl/mt_match.sv
module mt_match #(
    parameter int N      = 4,
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic [N-1:0]             ent_valid,
    input  logic [N-1:0]             ent_retire,
    input  logic [N-1:0]             ent_fill,
    input  logic [N-1:0]             ent_sent,
    input  logic [N-1:0][ADDR_W-1:0] ent_addr,
    input  logic [ADDR_W-1:0]        blk_addr,
    output logic                     hit,
    output logic [IDX_W-1:0]         hit_idx,
    output logic                     free_any,
    output logic [IDX_W-1:0]         free_idx,
    output logic                     pend_any,
    output logic [IDX_W-1:0]         pend_idx
);
    logic [N-1:0] eq_vec;
    logic [N-1:0] free_vec;
    logic [N-1:0] pend_vec;

    for (genvar g = 0; g < N; g++) begin : g_ent
        assign eq_vec[g]   = ent_valid[g] && !ent_retire[g] && ent_fill[g]
                             && (ent_addr[g] == blk_addr);
        assign free_vec[g] = !ent_valid[g];
        assign pend_vec[g] = ent_valid[g] && !ent_sent[g];
    end

    // lowest index wins in each search
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        pend_any = 1'b0;
        pend_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (free_vec[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (pend_vec[i]) begin
                pend_any = 1'b1;
                pend_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mt_retire_fsm.sv
module mt_retire_fsm
    import mt_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mrsp_valid,
    input  logic [IDX_W-1:0] mrsp_tag,
    input  logic             mrsp_err,
    input  logic [N-1:0]     ent_fill,
    input  logic [CNT_W-1:0] ret_cnt,
    input  logic             tr_ready,
    output logic             mrsp_ready,
    output logic             rsp_acc,
    output logic [IDX_W-1:0] ret_idx,
    output logic             ret_err,
    output logic [CNT_W-1:0] rd_ptr,
    output logic             fill_stb,
    output logic             tr_valid,
    output logic             ret_done
);
    ret_state_e state, nxt;
    logic       last_tgt;

    assign last_tgt = (rd_ptr + CNT_W'(1)) == ret_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RS_IDLE;
            ret_idx <= '0;
            ret_err <= 1'b0;
            rd_ptr  <= '0;
        end else begin
            state <= nxt;
            if (rsp_acc) begin
                ret_idx <= mrsp_tag;
                ret_err <= mrsp_err;
                rd_ptr  <= '0;
            end else if (tr_valid && tr_ready) begin
                rd_ptr <= rd_ptr + CNT_W'(1);
            end
        end
    end

    always_comb begin
        nxt        = state;
        mrsp_ready = 1'b0;
        rsp_acc    = 1'b0;
        fill_stb   = 1'b0;
        tr_valid   = 1'b0;
        ret_done   = 1'b0;
        unique case (state)
            RS_IDLE: begin
                mrsp_ready = 1'b1;
                if (mrsp_valid) begin
                    rsp_acc = 1'b1;
                    nxt = (ent_fill[mrsp_tag] && !mrsp_err) ? RS_INSTALL : RS_DRAIN;
                end
            end
            RS_INSTALL: begin
                fill_stb = 1'b1;
                nxt      = RS_DRAIN;
            end
            RS_DRAIN: begin
                tr_valid = 1'b1;
                if (tr_ready && last_tgt) begin
                    ret_done = 1'b1;
                    nxt      = RS_IDLE;
                end
            end
            default: nxt = RS_IDLE;
        endcase
    end

    // R11
    drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tr_valid && !tr_ready) |=> (tr_valid && $stable(rd_ptr)));

endmodule

// File: rtl/miss_track_unit.sv
module miss_track_unit
    import mt_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BLK_BYTES   = 16,
    parameter int NUM_MSHR    = 4,
    parameter int NUM_TARGETS = 4,
    parameter int ID_W        = 4,
    parameter int ORD_W       = 8,
    parameter int IDX_W       = (NUM_MSHR > 1) ? $clog2(NUM_MSHR) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [ID_W-1:0]   lk_id,
    input  logic              lk_uncache,
    input  logic              lk_read,
    input  logic              lk_write,
    input  logic              lk_wb,
    input  logic              lk_excl,
    input  logic              lk_blk_valid,
    input  logic              lk_blk_writable,
    output logic              stall_tgt,
    output logic              stall_full,
    output logic              wbuf_valid,
    output logic [ADDR_W-1:0] wbuf_addr,
    output logic [ID_W-1:0]   wbuf_id,
    output logic              blk_clr_rd,
    output logic [ADDR_W-1:0] blk_clr_addr,
    output logic              blk_fill,
    output logic [ADDR_W-1:0] blk_fill_addr,
    output logic              mreq_valid,
    input  logic              mreq_ready,
    output logic [ADDR_W-1:0] mreq_addr,
    output logic [1:0]        mreq_cmd,
    output logic [IDX_W-1:0]  mreq_tag,
    input  logic              mrsp_valid,
    output logic              mrsp_ready,
    input  logic [IDX_W-1:0]  mrsp_tag,
    input  logic              mrsp_err,
    output logic              tr_valid,
    input  logic              tr_ready,
    output logic [ID_W-1:0]   tr_id,
    output logic [ORD_W-1:0]  tr_order,
    output logic              tr_err
);
    localparam int CNT_W = $clog2(NUM_TARGETS + 1);
    localparam int PTR_W = (NUM_TARGETS > 1) ? $clog2(NUM_TARGETS) : 1;
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLK_BYTES - 1);

    // entry state
    logic [NUM_MSHR-1:0]                              ent_valid;
    logic [NUM_MSHR-1:0]                              ent_retire;
    logic [NUM_MSHR-1:0]                              ent_fill;
    logic [NUM_MSHR-1:0]                              ent_sent;
    logic [NUM_MSHR-1:0][ADDR_W-1:0]                  ent_addr;
    logic [NUM_MSHR-1:0][1:0]                         ent_cmd;
    logic [NUM_MSHR-1:0][CNT_W-1:0]                   ent_cnt;
    logic [NUM_MSHR-1:0][NUM_TARGETS-1:0][ID_W-1:0]   tgt_id;
    logic [NUM_MSHR-1:0][NUM_TARGETS-1:0][ORD_W-1:0]  tgt_ord;

    logic [ORD_W-1:0] ord_ctr;
    logic             stall_q;
    logic [IDX_W-1:0] stall_idx_q;
    logic             iss_busy;
    logic [IDX_W-1:0] iss_idx;

    // lookup decode
    logic [ADDR_W-1:0] lk_blk;
    route_e            route;
    mem_cmd_e          sel_cmd;
    logic              sel_clr;
    logic              hit, free_any, pend_any;
    logic [IDX_W-1:0]  hit_idx, free_idx, pend_idx;
    logic [NUM_MSHR-1:0] retire_mask;
    logic              acc, do_merge, do_alloc, do_wbuf;

    // retire side
    logic             rsp_acc, ret_err, fill_stb, ret_done;
    logic [IDX_W-1:0] ret_idx;
    logic [CNT_W-1:0] rd_ptr;
    logic [CNT_W-1:0] ret_cnt;

    assign lk_blk = lk_addr & ~OFF_MASK;

    mt_cmd_sel u_cmd (
        .uncache      (lk_uncache),
        .is_read      (lk_read),
        .is_write     (lk_write),
        .is_wb        (lk_wb),
        .need_excl    (lk_excl),
        .blk_valid    (lk_blk_valid),
        .blk_writable (lk_blk_writable),
        .route        (route),
        .cmd          (sel_cmd),
        .clr_rd       (sel_clr)
    );

    // an entry whose response is being taken this cycle no longer merges
    always_comb begin
        retire_mask = ent_retire;
        if (rsp_acc) retire_mask[mrsp_tag] = 1'b1;
    end

    mt_match #(.N(NUM_MSHR), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
        .ent_valid  (ent_valid),
        .ent_retire (retire_mask),
        .ent_fill   (ent_fill),
        .ent_sent   (ent_sent),
        .ent_addr   (ent_addr),
        .blk_addr   (lk_blk),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .free_any   (free_any),
        .free_idx   (free_idx),
        .pend_any   (pend_any),
        .pend_idx   (pend_idx)
    );

    assign ret_cnt = ent_cnt[ret_idx];

    mt_retire_fsm #(.N(NUM_MSHR), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ret (
        .clk        (clk),
        .rst        (rst),
        .mrsp_valid (mrsp_valid),
        .mrsp_tag   (mrsp_tag),
        .mrsp_err   (mrsp_err),
        .ent_fill   (ent_fill),
        .ret_cnt    (ret_cnt),
        .tr_ready   (tr_ready),
        .mrsp_ready (mrsp_ready),
        .rsp_acc    (rsp_acc),
        .ret_idx    (ret_idx),
        .ret_err    (ret_err),
        .rd_ptr     (rd_ptr),
        .fill_stb   (fill_stb),
        .tr_valid   (tr_valid),
        .ret_done   (ret_done)
    );

    assign stall_tgt  = stall_q;
    assign stall_full = !free_any;
    assign lk_ready   = !stall_q && free_any;

    assign acc      = lk_valid && lk_ready;
    assign do_merge = acc && (route == RT_CACHE) && hit;
    assign do_alloc = acc && (((route == RT_CACHE) && !hit) || (route == RT_UNCACHED));
    assign do_wbuf  = acc && (route == RT_WBUF);

    // entry table
    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid   <= '0;
            ent_retire  <= '0;
            ent_fill    <= '0;
            ent_sent    <= '0;
            ent_addr    <= '0;
            ent_cmd     <= '0;
            ent_cnt     <= '0;
            tgt_id      <= '0;
            tgt_ord     <= '0;
            ord_ctr     <= '0;
            stall_q     <= 1'b0;
            stall_idx_q <= '0;
            iss_busy    <= 1'b0;
            iss_idx     <= '0;
        end else begin
            if (do_alloc) begin
                ent_valid[free_idx]     <= 1'b1;
                ent_retire[free_idx]    <= 1'b0;
                ent_fill[free_idx]      <= (route == RT_CACHE);
                ent_sent[free_idx]      <= 1'b0;
                ent_addr[free_idx]      <= (route == RT_CACHE) ? lk_blk : lk_addr;
                ent_cmd[free_idx]       <= sel_cmd;
                ent_cnt[free_idx]       <= CNT_W'(1);
                tgt_id[free_idx][0]     <= lk_id;
                tgt_ord[free_idx][0]    <= ord_ctr;
                ord_ctr                 <= ord_ctr + ORD_W'(1);
                if ((route == RT_CACHE) && (NUM_TARGETS == 1)) begin
                    stall_q     <= 1'b1;
                    stall_idx_q <= free_idx;
                end
            end
            if (do_merge) begin
                tgt_id[hit_idx][PTR_W'(ent_cnt[hit_idx])]  <= lk_id;
                tgt_ord[hit_idx][PTR_W'(ent_cnt[hit_idx])] <= ord_ctr;
                ent_cnt[hit_idx] <= ent_cnt[hit_idx] + CNT_W'(1);
                ord_ctr          <= ord_ctr + ORD_W'(1);
                if ((ent_cnt[hit_idx] + CNT_W'(1)) == CNT_W'(NUM_TARGETS)) begin
                    stall_q     <= 1'b1;
                    stall_idx_q <= hit_idx;
                end
            end
            // issue stage: latch one unsent entry, hold it until taken
            if (iss_busy) begin
                if (mreq_ready) begin
                    ent_sent[iss_idx] <= 1'b1;
                    iss_busy          <= 1'b0;
                end
            end else if (pend_any) begin
                iss_busy <= 1'b1;
                iss_idx  <= pend_idx;
            end
            if (rsp_acc) begin
                ent_retire[mrsp_tag] <= 1'b1;
                if (stall_q && (stall_idx_q == mrsp_tag)) stall_q <= 1'b0;
            end
            if (ret_done) begin
                ent_valid[ret_idx]  <= 1'b0;
                ent_retire[ret_idx] <= 1'b0;
            end
        end
    end

    // one-cycle strobes toward write buffer and tag array
    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf_valid   <= 1'b0;
            wbuf_addr    <= '0;
            wbuf_id      <= '0;
            blk_clr_rd   <= 1'b0;
            blk_clr_addr <= '0;
        end else begin
            wbuf_valid <= do_wbuf;
            if (do_wbuf) begin
                wbuf_addr <= lk_addr;
                wbuf_id   <= lk_id;
            end
            blk_clr_rd <= acc && (route == RT_CACHE) && sel_clr;
            if (acc && (route == RT_CACHE) && sel_clr) blk_clr_addr <= lk_blk;
        end
    end

    assign mreq_valid    = iss_busy;
    assign mreq_tag      = iss_idx;
    assign mreq_addr     = ent_addr[iss_idx];
    assign mreq_cmd      = ent_cmd[iss_idx];

    assign blk_fill      = fill_stb;
    assign blk_fill_addr = ent_addr[ret_idx];

    assign tr_id    = tgt_id[ret_idx][PTR_W'(rd_ptr)];
    assign tr_order = tgt_ord[ret_idx][PTR_W'(rd_ptr)];
    assign tr_err   = ret_err;

    // R8
    tgt_stall_release_chk: assert property (@(posedge clk) disable iff (rst)
        (stall_tgt && mrsp_valid && mrsp_ready && (mrsp_tag == stall_idx_q)) |=> !stall_tgt);

    // R12
    mreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_tag) && $stable(mreq_addr)));

    // R10
    fill_then_target_chk: assert property (@(posedge clk) disable iff (rst)
        blk_fill |=> (tr_valid && !tr_err));

    // R6
    wbuf_excl_clr_chk: assert property (@(posedge clk) disable iff (rst)
        wbuf_valid |-> !blk_clr_rd);

endmodule

// File: tb/tb_miss_track_unit.sv
module tb_miss_track_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid, lk_ready;
    logic [15:0] lk_addr;
    logic [3:0]  lk_id;
    logic        lk_uncache, lk_read, lk_write, lk_wb, lk_excl, lk_blk_valid, lk_blk_writable;
    logic        stall_tgt, stall_full;
    logic        wbuf_valid;
    logic [15:0] wbuf_addr;
    logic [3:0]  wbuf_id;
    logic        blk_clr_rd, blk_fill;
    logic [15:0] blk_clr_addr, blk_fill_addr;
    logic        mreq_valid, mreq_ready;
    logic [15:0] mreq_addr;
    logic [1:0]  mreq_cmd, mreq_tag;
    logic        mrsp_valid, mrsp_ready, mrsp_err;
    logic [1:0]  mrsp_tag;
    logic        tr_valid, tr_ready, tr_err;
    logic [3:0]  tr_id;
    logic [7:0]  tr_order;

    always #5 clk = ~clk;

    miss_track_unit dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr), .lk_id(lk_id),
        .lk_uncache(lk_uncache), .lk_read(lk_read), .lk_write(lk_write), .lk_wb(lk_wb),
        .lk_excl(lk_excl), .lk_blk_valid(lk_blk_valid), .lk_blk_writable(lk_blk_writable),
        .stall_tgt(stall_tgt), .stall_full(stall_full),
        .wbuf_valid(wbuf_valid), .wbuf_addr(wbuf_addr), .wbuf_id(wbuf_id),
        .blk_clr_rd(blk_clr_rd), .blk_clr_addr(blk_clr_addr),
        .blk_fill(blk_fill), .blk_fill_addr(blk_fill_addr),
        .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
        .mreq_cmd(mreq_cmd), .mreq_tag(mreq_tag),
        .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_tag(mrsp_tag), .mrsp_err(mrsp_err),
        .tr_valid(tr_valid), .tr_ready(tr_ready), .tr_id(tr_id), .tr_order(tr_order), .tr_err(tr_err)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // scoreboards
    logic [12:0] exp_tr[$];   // {id, order, err}
    logic [19:0] exp_mq[$];   // {tag, cmd, addr}

    // bench model of entries
    bit          mv[4];
    bit          mfill[4];
    logic [15:0] maddr[4];
    int          mn[4];
    logic [3:0]  mid[4][4];
    logic [7:0]  mord[4][4];
    logic [7:0]  ord = 8'd0;
    bit          mstall = 1'b0;
    int          mstall_idx = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog all requirements actual=%0d expected=%0d", cyc, 100000);
            report();
            $finish;
        end
    end

    // request monitor (R4 R12)
    always @(negedge clk) begin
        if (!rst && mreq_valid && mreq_ready) begin
            if (exp_mq.size() == 0) begin
                chk(1'b0, "R3", "unexpected mreq addr", int'(mreq_addr), 0);
            end else begin
                logic [19:0] e;
                e = exp_mq.pop_front();
                chk(mreq_tag == e[19:18], "R12", "mreq_tag", int'(mreq_tag), int'(e[19:18]));
                chk(mreq_cmd == e[17:16], "R4", "mreq_cmd", int'(mreq_cmd), int'(e[17:16]));
                chk(mreq_addr == e[15:0], "R4", "mreq_addr", int'(mreq_addr), int'(e[15:0]));
            end
        end
    end

    // target monitor (R11 R10 R3)
    always @(negedge clk) begin
        if (!rst && tr_valid && tr_ready) begin
            if (exp_tr.size() == 0) begin
                chk(1'b0, "R11", "unexpected target id", int'(tr_id), 0);
            end else begin
                logic [12:0] e;
                e = exp_tr.pop_front();
                chk(tr_id == e[12:9], "R11", "tr_id", int'(tr_id), int'(e[12:9]));
                chk(tr_order == e[8:1], "R3", "tr_order", int'(tr_order), int'(e[8:1]));
                chk(tr_err == e[0], "R10", "tr_err", int'(tr_err), int'(e[0]));
            end
        end
    end

    task automatic lookup(input logic [15:0] a, input logic [3:0] id,
                          input bit unc, input bit rd, input bit wr, input bit wb,
                          input bit ex, input bit bv, input bit bw);
        bit wbp, uncp, clr;
        logic [15:0] blk;
        logic [1:0]  cmd;
        int hit, fr;
        wbp  = (unc && wr && !rd) || (!unc && wb);
        uncp = unc && !wbp;
        blk  = a & 16'hFFF0;
        clr  = !unc && !wb && bv && wr && !bw;
        cmd  = uncp ? 2'd3 : (bv ? 2'd2 : (ex ? 2'd1 : 2'd0));
        hit  = -1;
        fr   = -1;
        if (!wbp && !uncp)
            for (int i = 3; i >= 0; i--)
                if (mv[i] && mfill[i] && maddr[i] == blk) hit = i;
        if (!wbp && hit < 0)
            for (int i = 3; i >= 0; i--)
                if (!mv[i]) fr = i;
        @(negedge clk);
        chk(lk_ready == 1'b1, "R9", "lk_ready before lookup", int'(lk_ready), 1);
        lk_valid = 1'b1; lk_addr = a; lk_id = id; lk_uncache = unc; lk_read = rd;
        lk_write = wr; lk_wb = wb; lk_excl = ex; lk_blk_valid = bv; lk_blk_writable = bw;
        if (fr >= 0) begin
            mv[fr] = 1'b1; mfill[fr] = !uncp; maddr[fr] = uncp ? a : blk; mn[fr] = 1;
            mid[fr][0] = id; mord[fr][0] = ord; ord = ord + 8'd1;
            exp_mq.push_back({2'(fr), cmd, maddr[fr]});
        end else if (hit >= 0) begin
            mid[hit][mn[hit]] = id; mord[hit][mn[hit]] = ord; ord = ord + 8'd1;
            mn[hit] = mn[hit] + 1;
            if (mn[hit] == 4) begin mstall = 1'b1; mstall_idx = hit; end
        end
        @(negedge clk);
        lk_valid = 1'b0;
        chk(wbuf_valid == wbp, (unc ? "R6" : "R7"), "wbuf_valid", int'(wbuf_valid), int'(wbp));
        if (wbp) begin
            chk(wbuf_addr == a, (unc ? "R6" : "R7"), "wbuf_addr", int'(wbuf_addr), int'(a));
            chk(wbuf_id == id, (unc ? "R6" : "R7"), "wbuf_id", int'(wbuf_id), int'(id));
        end
        chk(blk_clr_rd == clr, "R5", "blk_clr_rd", int'(blk_clr_rd), int'(clr));
        if (clr) chk(blk_clr_addr == blk, "R5", "blk_clr_addr", int'(blk_clr_addr), int'(blk));
        if (hit >= 0 && mn[hit] == 4) begin
            chk(stall_tgt == 1'b1, "R8", "stall_tgt after list full", int'(stall_tgt), 1);
            chk(lk_ready == 1'b0, "R8", "lk_ready while target stall", int'(lk_ready), 0);
        end
    endtask

    task automatic respond(input int tag, input bit err);
        bit fexp, sclr;
        while (exp_mq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        mrsp_valid = 1'b1; mrsp_tag = 2'(tag); mrsp_err = err;
        while (!mrsp_ready) @(negedge clk);
        for (int i = 0; i < mn[tag]; i++) exp_tr.push_back({mid[tag][i], mord[tag][i], err});
        fexp = mfill[tag] && !err;
        sclr = mstall && (mstall_idx == tag);
        mv[tag] = 1'b0;
        @(negedge clk);
        mrsp_valid = 1'b0;
        chk(blk_fill == fexp, "R10", "blk_fill", int'(blk_fill), int'(fexp));
        if (fexp) chk(blk_fill_addr == maddr[tag], "R10", "blk_fill_addr", int'(blk_fill_addr), int'(maddr[tag]));
        if (sclr) begin
            chk(stall_tgt == 1'b0, "R8", "stall_tgt after response", int'(stall_tgt), 0);
            mstall = 1'b0;
        end
    endtask

    task automatic wait_drain();
        int guard = 0;
        while ((exp_tr.size() != 0 || tr_valid) && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(exp_tr.size() == 0, "R11", "targets left undelivered", exp_tr.size(), 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; lk_valid = 1'b0; lk_addr = '0; lk_id = '0; lk_uncache = 1'b0;
        lk_read = 1'b0; lk_write = 1'b0; lk_wb = 1'b0; lk_excl = 1'b0;
        lk_blk_valid = 1'b0; lk_blk_writable = 1'b0; mreq_ready = 1'b1;
        mrsp_valid = 1'b0; mrsp_tag = '0; mrsp_err = 1'b0; tr_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin mv[i] = 1'b0; mfill[i] = 1'b0; maddr[i] = '0; mn[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(lk_ready == 1'b1, "R1", "lk_ready", int'(lk_ready), 1);
        chk(mrsp_ready == 1'b1, "R1", "mrsp_ready", int'(mrsp_ready), 1);
        chk({stall_tgt, stall_full, mreq_valid, tr_valid, wbuf_valid, blk_fill, blk_clr_rd} == 7'b0,
            "R1", "idle outputs", int'({stall_tgt, stall_full, mreq_valid, tr_valid, wbuf_valid, blk_fill, blk_clr_rd}), 0);

        // R4 plain read, fill and single target
        lookup(16'h1234, 4'd1, 0, 1, 0, 0, 0, 0, 0);
        respond(0, 1'b0);
        wait_drain();

        // R4 read-exclusive, R5 upgrade with readable clear, R2 merge and split
        lookup(16'h2004, 4'd2, 0, 0, 1, 0, 1, 0, 0);
        lookup(16'h3008, 4'd3, 0, 0, 1, 0, 1, 1, 0);
        lookup(16'h200C, 4'd4, 0, 1, 0, 0, 0, 0, 0);
        lookup(16'h2010, 4'd5, 0, 1, 0, 0, 0, 0, 0);
        respond(1, 1'b1);   // R10 error: no install
        respond(0, 1'b0);
        respond(2, 1'b0);
        wait_drain();

        // R6 uncached write, R7 writeback, R6 uncached reads never merge
        lookup(16'h4444, 4'd6, 1, 0, 1, 0, 0, 0, 0);
        lookup(16'h5550, 4'd7, 0, 0, 0, 1, 0, 0, 0);
        lookup(16'h4440, 4'd8, 1, 1, 0, 0, 0, 0, 0);
        lookup(16'h4440, 4'd9, 1, 1, 0, 0, 0, 0, 0);
        respond(1, 1'b0);
        respond(0, 1'b0);
        wait_drain();

        // R8 target stall; R11 back-pressure on returns
        lookup(16'h6000, 4'd10, 0, 1, 0, 0, 0, 0, 0);
        lookup(16'h6004, 4'd11, 0, 1, 0, 0, 0, 0, 0);
        lookup(16'h6008, 4'd12, 0, 1, 0, 0, 0, 0, 0);
        lookup(16'h600F, 4'd13, 0, 1, 0, 0, 0, 0, 0);
        tr_ready = 1'b0;
        respond(0, 1'b0);
        repeat (3) @(negedge clk);
        chk(tr_valid == 1'b1, "R11", "tr_valid held under back-pressure", int'(tr_valid), 1);
        chk(tr_id == 4'd10, "R11", "first target held", int'(tr_id), 10);
        tr_ready = 1'b1;
        wait_drain();

        // R9 all entries busy
        lookup(16'h7000, 4'd1, 0, 1, 0, 0, 0, 0, 0);
        lookup(16'h7100, 4'd2, 0, 1, 0, 0, 1, 0, 0);
        lookup(16'h7200, 4'd3, 0, 1, 0, 0, 0, 0, 0);
        lookup(16'h7300, 4'd4, 0, 1, 0, 0, 1, 0, 0);
        chk(stall_full == 1'b1, "R9", "stall_full", int'(stall_full), 1);
        chk(lk_ready == 1'b0, "R9", "lk_ready when full", int'(lk_ready), 0);
        respond(3, 1'b0);
        respond(2, 1'b1);
        respond(1, 1'b0);
        respond(0, 1'b0);
        wait_drain();
        chk(stall_full == 1'b0, "R11", "entries freed after drain", int'(stall_full), 0);

        report();
        $finish;
    end
endmodule